// File: doc/BRIEF.md
# Startup and Resistor Voltage-Select Sequencer

This block brings a switching converter from off to its working output voltage. When enabled, it holds the converter in discontinuous conduction with the soft-start peak-current limits selected, and it aims the output at the lowest programmable voltage. Once the converter reports power-good, the block turns on the current source that reads the external selection resistor. It keeps that source on only for a bounded detection window.

The detected resistor code is translated into a 6-bit output-voltage code. The voltage code counts 50 mV steps above 2.5 V. The target then climbs toward that code, either one step per programmable interval or in a single jump. When the target reaches its final value, the block releases the startup overrides and raises output-good. From then on, host writes to the voltage code take effect on the next cycle without a restart. Dropping enable returns everything to the idle state.

Top module: `startup_vsel_seq`

## Requirements
- R1: After a cycle with rst_n low, or while idle, vtarget is 0 and meas_en, dcm_force, ss_sel and out_good are all low.
- R2: The cycle after en is first sampled high, ss_sel and dcm_force are high, vtarget is 0 (2.5 V), and meas_en stays low while pgood is low.
- R3: meas_en rises the cycle after pgood is sampled high during startup. It stays high at most DET_CYCLES cycles, and it falls the cycle after rcode_vld is sampled high.
- R4: A sampled rcode of 1 to 15 selects 2.5, 2.7, 3.0, 3.2, 3.3, 3.4, 3.5, 3.6, 3.7, 3.8, 4.0, 4.2, 4.5, 5.0 and 5.5 V in that order. Code 15 is a shorted pin. The final vtarget is (V − 2.5 V) / 50 mV.
- R5: An rcode of 0 (open pin), or a window that ends without rcode_vld, selects DEFAULT_VCODE. If rcode_vld is sampled in the last window cycle, the sampled code wins.
- R6: With ramp_en high, vtarget rises by one code every ramp_intv+1 cycles until it equals the selected code.
- R7: With ramp_en low, vtarget takes the selected code one cycle after detection ends.
- R8: The cycle after vtarget equals the selected code, out_good rises and dcm_force and ss_sel fall. While out_good is high, they stay low.
- R9: A write (wr_en high) while out_good is low leaves vtarget unchanged.
- R10: A write while out_good is high sets vtarget to wr_data on the next cycle, and out_good stays high.
- R11: If en is sampled low in any state, the next cycle shows the idle outputs of R1. A write sampled in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable |
| pgood | input | 1 | Converter output within regulation |
| rcode | input | 4 | Detected resistor code (0 open, 15 short) |
| rcode_vld | input | 1 | rcode is valid this cycle |
| ramp_en | input | 1 | Step the target gradually instead of jumping |
| ramp_intv | input | RAMP_W | Extra cycles between ramp steps |
| wr_en | input | 1 | Host write strobe for the voltage code |
| wr_data | input | 6 | Host voltage code |
| vtarget | output | 6 | Output-voltage target code |
| meas_en | output | 1 | Resistor-measurement current enable |
| dcm_force | output | 1 | Force discontinuous conduction (valley at zero) |
| ss_sel | output | 1 | Use soft-start peak limits |
| out_good | output | 1 | Startup done, output at final voltage |

## Verification
Two collisions need cycle-exact treatment. The first is a valid resistor code arriving in the very cycle the detection window expires. The bench places rcode_vld exactly DET_CYCLES−1 cycles into the window and expects the detected code, not the default. The second is a host write landing in the same cycle that enable drops. The bench drives both strobes together and expects the idle outputs with vtarget 0 on the next cycle. A behavioural model runs in lockstep and judges every output on every clock around both events.

// File: rtl/vsel_seq_pkg.sv
// Package: shared widths, sequencer state type and the resistor-code to
// voltage-code mapping. Voltage code = (volts - 2.5) / 0.05.
package vsel_seq_pkg;
    localparam int VC_W = 6;
    localparam int RC_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOFT,
        ST_DETECT,
        ST_RAMP,
        ST_RUN
    } seq_state_t;

    // Table of the 15 selectable voltages; code 0 (open) returns 0 and is
    // replaced by the default in the caller.
    function automatic logic [VC_W-1:0] rcode_to_vcode(input logic [RC_W-1:0] c);
        case (c)
            4'd1:    return 6'd0;
            4'd2:    return 6'd4;
            4'd3:    return 6'd10;
            4'd4:    return 6'd14;
            4'd5:    return 6'd16;
            4'd6:    return 6'd18;
            4'd7:    return 6'd20;
            4'd8:    return 6'd22;
            4'd9:    return 6'd24;
            4'd10:   return 6'd26;
            4'd11:   return 6'd30;
            4'd12:   return 6'd34;
            4'd13:   return 6'd40;
            4'd14:   return 6'd50;
            4'd15:   return 6'd60;
            default: return 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/vsel_win_timer.sv
// Detection window timer. Counts cycles while run is high and flags the
// last cycle of a LIMIT-cycle window. Assumes LIMIT >= 1; clears when idle.
module vsel_win_timer #(
    parameter int LIMIT = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Window position counter, restarted whenever the window is closed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/vsel_ramp_tick.sv
// Ramp pacing. While run is high, emits one tick every interval+1 cycles,
// the first one interval cycles after run rises. Counter never exceeds interval.
module vsel_ramp_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] interval,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt >= interval);

    // Interval counter, reset on each tick and when not ramping.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/vsel_rsel_decode.sv
// Translates the detected resistor code to a voltage code; an open pin
// (code 0) yields DEFAULT_VCODE. Purely combinational.
module vsel_rsel_decode
    import vsel_seq_pkg::*;
#(
    parameter logic [VC_W-1:0] DEFAULT_VCODE = 6'd16
) (
    input  logic [RC_W-1:0] rcode,
    output logic [VC_W-1:0] vcode
);
    // Open pin picks the default, every other code uses the table.
    always_comb begin
        if (rcode == '0) vcode = DEFAULT_VCODE;
        else             vcode = rcode_to_vcode(rcode);
    end
endmodule

// File: rtl/startup_vsel_seq.sv
// Startup sequencer: soft start at the minimum voltage, resistor detection
// after power-good, ramp to the selected code, then release the overrides
// and accept host writes. Assumes inputs are synchronous to clk.
module startup_vsel_seq
    import vsel_seq_pkg::*;
#(
    parameter int               RAMP_W        = 8,
    parameter int               DET_CYCLES    = 75000,
    parameter logic [VC_W-1:0]  DEFAULT_VCODE = 6'd16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pgood,
    input  logic [RC_W-1:0]   rcode,
    input  logic              rcode_vld,
    input  logic              ramp_en,
    input  logic [RAMP_W-1:0] ramp_intv,
    input  logic              wr_en,
    input  logic [VC_W-1:0]   wr_data,
    output logic [VC_W-1:0]   vtarget,
    output logic              meas_en,
    output logic              dcm_force,
    output logic              ss_sel,
    output logic              out_good
);
    seq_state_t      state;
    logic [VC_W-1:0] goal;
    logic [VC_W-1:0] dec_vcode;
    logic            win_expire;
    logic            step_tick;

    vsel_win_timer #(.LIMIT(DET_CYCLES)) i_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_DETECT),
        .expire (win_expire)
    );

    vsel_ramp_tick #(.W(RAMP_W)) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_RAMP),
        .interval (ramp_intv),
        .tick     (step_tick)
    );

    vsel_rsel_decode #(.DEFAULT_VCODE(DEFAULT_VCODE)) i_dec (
        .rcode (rcode),
        .vcode (dec_vcode)
    );

    // Sequencer state, voltage target and selected goal.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= ST_IDLE;
            vtarget <= '0;
            goal    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state   <= ST_SOFT;
                    vtarget <= '0;
                end
                ST_SOFT: begin
                    if (pgood) state <= ST_DETECT;
                end
                ST_DETECT: begin
                    if (rcode_vld) begin
                        goal  <= dec_vcode;
                        state <= ST_RAMP;
                    end else if (win_expire) begin
                        goal  <= DEFAULT_VCODE;
                        state <= ST_RAMP;
                    end
                end
                ST_RAMP: begin
                    if (vtarget == goal)   state   <= ST_RUN;
                    else if (!ramp_en)     vtarget <= goal;
                    else if (step_tick) begin
                        if (vtarget < goal) vtarget <= vtarget + 1'b1;
                        else                vtarget <= vtarget - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (wr_en) vtarget <= wr_data;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign meas_en   = (state == ST_DETECT);
    assign ss_sel    = (state == ST_SOFT) || (state == ST_DETECT) || (state == ST_RAMP);
    assign dcm_force = ss_sel;
    assign out_good  = (state == ST_RUN);
endmodule

// File: rtl/startup_vsel_seq_chk.sv
// Checker for startup_vsel_seq: port-level temporal properties, bound below.
module startup_vsel_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       ramp_en,
    input logic       wr_en,
    input logic [5:0] wr_data,
    input logic [5:0] vtarget,
    input logic       meas_en,
    input logic       dcm_force,
    input logic       ss_sel,
    input logic       out_good
);
    p_enter_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_sel) |-> (vtarget == 6'd0));

    p_meas_startup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_en |-> (dcm_force && ss_sel && !out_good && vtarget == 6'd0));

    p_ramp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_sel && !meas_en && $past(ss_sel) && !$past(meas_en) && $past(ramp_en))
        |-> (vtarget == $past(vtarget) || vtarget == $past(vtarget) + 6'd1));

    p_good_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_good |-> (!dcm_force && !ss_sel && !meas_en));

    p_write_apply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_good && en && wr_en) |=> (out_good && vtarget == $past(wr_data)));

    p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!out_good && !meas_en && !ss_sel && !dcm_force && vtarget == 6'd0));
endmodule

bind startup_vsel_seq startup_vsel_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ramp_en   (ramp_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .vtarget   (vtarget),
    .meas_en   (meas_en),
    .dcm_force (dcm_force),
    .ss_sel    (ss_sel),
    .out_good  (out_good)
);

// File: tb/test_startup_vsel_seq.sv
// Bench: lockstep behavioural model compared on every clock, plus directed
// scenario checks.
module test_startup_vsel_seq;
    localparam int DET = 20;
    localparam int DEFV = 16;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       en = 0, pgood = 0, rcode_vld = 0, ramp_en = 0, wr_en = 0;
    logic [3:0] rcode = 0;
    logic [7:0] ramp_intv = 0;
    logic [5:0] wr_data = 0;
    logic [5:0] vtarget;
    logic       meas_en, dcm_force, ss_sel, out_good;

    int tests = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // model state: 0 idle, 1 soft, 2 detect, 3 ramp, 4 run
    int m_st = 0, m_vt = 0, m_goal = 0, m_wc = 0, m_rc = 0;

    always #5 clk = ~clk;

    startup_vsel_seq #(.RAMP_W(8), .DET_CYCLES(DET), .DEFAULT_VCODE(6'(DEFV))) i_startup_vsel_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .pgood(pgood), .rcode(rcode),
        .rcode_vld(rcode_vld), .ramp_en(ramp_en), .ramp_intv(ramp_intv),
        .wr_en(wr_en), .wr_data(wr_data), .vtarget(vtarget), .meas_en(meas_en),
        .dcm_force(dcm_force), .ss_sel(ss_sel), .out_good(out_good)
    );

    function automatic int mv_of(input int c);
        int tbl[16] = '{0, 2500, 2700, 3000, 3200, 3300, 3400, 3500, 3600,
                        3700, 3800, 4000, 4200, 4500, 5000, 5500};
        return tbl[c];
    endfunction

    function automatic int expect_code(input int c);
        if (c == 0) return DEFV;
        return (mv_of(c) - 2500) / 50;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || !en) begin
            m_st = 0; m_vt = 0; m_goal = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_vt = 0; end
                1: if (pgood) begin m_st = 2; m_wc = 0; end
                2: begin
                    if (rcode_vld) begin m_goal = expect_code(rcode); m_st = 3; m_rc = 0; end
                    else if (m_wc == DET - 1) begin m_goal = DEFV; m_st = 3; m_rc = 0; end
                    else m_wc++;
                end
                3: begin
                    bit tk;
                    tk = (m_rc >= ramp_intv);
                    m_rc = tk ? 0 : m_rc + 1;
                    if (m_vt == m_goal) m_st = 4;
                    else if (!ramp_en) m_vt = m_goal;
                    else if (tk) m_vt = (m_vt < m_goal) ? m_vt + 1 : m_vt - 1;
                end
                4: if (wr_en) m_vt = wr_data;
                default: m_st = 0;
            endcase
        end
    end

    // Compare all outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk(vtarget == 6'(m_vt), tag, vtarget, m_vt);
            chk(meas_en == (m_st == 2), "R3", meas_en, m_st == 2);
            chk(ss_sel == (m_st inside {1, 2, 3}), "R8", ss_sel, m_st inside {1, 2, 3});
            chk(dcm_force == (m_st inside {1, 2, 3}), "R8", dcm_force, m_st inside {1, 2, 3});
            chk(out_good == (m_st == 4), "R8", out_good, m_st == 4);
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wait_good(input string req, input int exp);
        int k = 0;
        while (!out_good && k < 400) begin step(1); k++; end
        chk(out_good, req, out_good, 1);
        chk(vtarget == 6'(exp), req, vtarget, exp);
    endtask

    // Start a sequence; vld_at = cycles after pgood drive (<0: no valid).
    task automatic start(input int code, input int vld_at, input bit ramp, input int intv);
        ramp_en = ramp; ramp_intv = 8'(intv); rcode = 4'(code);
        en = 1;
        step(2);
        chk(ss_sel && dcm_force && vtarget == 0, "R2", vtarget, 0);
        step(2);
        chk(!meas_en, "R2", meas_en, 0);
        pgood = 1;
        step(1);
        chk(meas_en, "R3", meas_en, 1);
        if (vld_at >= 0) begin
            if (vld_at > 1) step(vld_at - 1);
            rcode_vld = 1;
            step(1);
            rcode_vld = 0;
            chk(!meas_en, "R3", meas_en, 0);
        end
    endtask

    task automatic stop();
        en = 0; pgood = 0;
        step(1);
        chk(!out_good && vtarget == 0 && !ss_sel, "R11", vtarget, 0);
        step(1);
    endtask

    initial begin
        step(3);
        tag = "R1";
        chk(vtarget == 0 && !meas_en && !ss_sel && !dcm_force && !out_good, "R1", vtarget, 0);
        rst_n = 1;
        step(2);
        chk(vtarget == 0 && !out_good && !ss_sel, "R1", vtarget, 0);

        // Ramped start to 3.5 V with interval 2, write lockout then write.
        tag = "R6";
        start(7, 3, 1, 2);
        step(4);
        wr_en = 1; wr_data = 6'd63; step(1); wr_en = 0;
        chk(vtarget != 6'd63, "R9", vtarget, 63);
        wait_good("R6", 20);
        chk(!dcm_force && !ss_sel, "R8", dcm_force, 0);
        tag = "R10";
        wr_en = 1; wr_data = 6'd40; step(1); wr_en = 0;
        chk(vtarget == 6'd40 && out_good, "R10", vtarget, 40);
        stop();

        // Every resistor code with ramp disabled.
        tag = "R7";
        for (int c = 1; c < 16; c++) begin
            start(c, 2, 0, 0);
            step(1);
            chk(vtarget == 6'(expect_code(c)), "R7", vtarget, expect_code(c));
            wait_good("R4", expect_code(c));
            stop();
        end

        // Open pin code.
        tag = "R5";
        start(0, 4, 0, 0);
        wait_good("R5", DEFV);
        stop();

        // Window timeout, ramp interval 0.
        start(9, -1, 1, 0);
        step(DET + 2);
        chk(!meas_en, "R3", meas_en, 0);
        wait_good("R5", DEFV);
        stop();

        // Valid in the last window cycle wins over timeout.
        start(2, DET, 1, 1);
        wait_good("R5", 4);
        stop();

        // Write colliding with disable.
        tag = "R11";
        start(3, 2, 0, 0);
        wait_good("R4", 10);
        wr_en = 1; wr_data = 6'd55; en = 0; pgood = 0;
        step(1);
        wr_en = 0;
        chk(vtarget == 0 && !out_good, "R11", vtarget, 0);
        step(2);

        // Disable in the middle of detection.
        start(5, -1, 1, 0);
        step(5);
        stop();
        chk(!meas_en, "R11", meas_en, 0);

        step(3);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule